// File: doc/BRIEF.md
# GOP Frame Type Sequencer

This block decides, one frame at a time, how a video encoder core should treat the next picture. Software starts each frame with a write to a control word whose start bit is 1. The sequencer then picks the register group the frame uses and decides from a programmable group-of-pictures length whether the frame is intra-coded (I) or predicted (P). It reports the frame number, the frame type and the group as status for the rest of the frame. The encoder pipeline is modelled as a completion input. When that input fires, the sequencer leaves its busy state and gives a one-cycle frame-done pulse.

Dual-stream operation takes effect only when both the dual-stream enable and the per-frame mode bit are set. Frames then alternate between group A and group B. Each group keeps its own frame count and its own position in its group of pictures, so the two streams follow independent I/P cadences. A soft-reset bit in the same control word puts the whole block back to its idle state.

Top module: `gop_frame_seq`

## Requirements
- R1: After the synchronous reset, busy, frame type, frame number, group select and frame-done all read 0.
- R2: A frame is accepted only on a cycle with ctl_wr=1 and ctl_start=1 while idle. A control write with ctl_start=0 leaves the block idle and its status unchanged.
- R3: With a GOP length N>0, each stream holds a position that starts at 0. A frame is intra (frame_intra=1) exactly when its position is 0. After each frame the position advances by one and returns to 0 once it reaches N, so frames 0, N, 2N... are I frames.
- R4: With a GOP length of 0, only a stream's first frame after reset is intra, and every later frame is P.
- R5: frame_num is 9 bits wide and shows how many earlier frames the same stream has started since reset. It wraps from 511 to 0.
- R6: When dual_en=1 and frame_mode=1, accepted frames alternate between group 0 (A) and group 1 (B), starting with A. grp_sel shows the group, and each group keeps its own frame number and GOP position.
- R7: When dual_en=1 but frame_mode=0, dual-stream operation is not in effect, and every frame uses group A with a single count.
- R8: busy is 1 from the cycle after an accepted start until the cycle after enc_done. A start request while busy is ignored.
- R9: frame_done is high for exactly one cycle, the cycle after enc_done is sampled while busy. enc_done while idle produces no pulse.
- R10: A control write with ctl_soft_rst=1 returns every output and every stream counter to the reset state, and it overrides a start bit in the same write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_start | input | 1 | Start bit of the control word |
| ctl_soft_rst | input | 1 | Soft-reset bit of the control word |
| frame_mode | input | 1 | 1: per-frame reference setup; 0: per-GOP setup |
| dual_en | input | 1 | Dual-stream enable |
| gop_len | input | 8 | Frames per GOP; 0 = unbounded |
| enc_done | input | 1 | Encoder reports the frame finished |
| busy | output | 1 | A frame is in progress |
| frame_intra | output | 1 | 1 = current frame is I, 0 = P |
| frame_num | output | 9 | Current frame number of the active stream |
| grp_sel | output | 1 | Register group of the current frame (0 = A, 1 = B) |
| frame_done | output | 1 | One-cycle frame completion pulse |

## Verification
Several single-stream runs tell the cadences apart. A GOP length of 3 gives I frames with period 3. A length of 0 gives one I frame followed only by P frames. A run of more than 512 frames shows the counter wrap. Dual-stream runs with a GOP length of 2 separate per-group counting from a shared count, and the same run with frame mode cleared shows that alternation needs both bits. Start requests sent while busy, completion pulses sent while idle, zero-start writes and a soft reset combined with a start each give a case that a correct design must ignore or override.

// File: rtl/gfs_pkg.sv
package gfs_pkg;
    localparam int GOP_W   = 8;
    localparam int FNUM_W  = 9;
    localparam int NUM_GRP = 2;

    typedef struct packed {
        logic              intra;
        logic [FNUM_W-1:0] num;
        logic              grp;
    } frame_stat_t;

    function automatic logic other_grp(input logic g, input logic dual);
        return dual ? ~g : 1'b0;
    endfunction
endpackage

// File: rtl/gfs_ctrl.sv
module gfs_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic start_req,
    input  logic enc_done,
    output logic busy,
    output logic frame_done,
    output logic launch
);
    assign launch = start_req && !busy;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            busy       <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= busy && enc_done;
            if (launch)
                busy <= 1'b1;
            else if (busy && enc_done)
                busy <= 1'b0;
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);
    // R8
    done_clears_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && enc_done && !clr) |=> (!busy && frame_done));
    // R2
    start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && start_req && !clr) |=> busy);
endmodule

// File: rtl/gfs_stream_track.sv
module gfs_stream_track #(
    parameter int GOP_W  = gfs_pkg::GOP_W,
    parameter int FNUM_W = gfs_pkg::FNUM_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              adv,
    input  logic [GOP_W-1:0]  gop_len,
    output logic              is_key,
    output logic [FNUM_W-1:0] fnum
);
    logic [GOP_W-1:0] pos;
    logic [GOP_W:0]   pos_inc;

    assign pos_inc = {1'b0, pos} + 1'b1;
    assign is_key  = (pos == '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pos  <= '0;
            fnum <= '0;
        end else if (adv) begin
            fnum <= fnum + 1'b1;
            if (gop_len == '0)
                pos <= (pos == '0) ? GOP_W'(1) : pos;
            else if (pos_inc >= {1'b0, gop_len})
                pos <= '0;
            else
                pos <= pos_inc[GOP_W-1:0];
        end
    end

    // R4
    unbounded_gop_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !clr && gop_len == '0) |=> !is_key);
    // R5
    fnum_step_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !clr) |=> (fnum == FNUM_W'($past(fnum) + 1'b1)));
endmodule

// File: rtl/gop_frame_seq.sv
module gop_frame_seq
    import gfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic              ctl_start,
    input  logic              ctl_soft_rst,
    input  logic              frame_mode,
    input  logic              dual_en,
    input  logic [GOP_W-1:0]  gop_len,
    input  logic              enc_done,
    output logic              busy,
    output logic              frame_intra,
    output logic [FNUM_W-1:0] frame_num,
    output logic              grp_sel,
    output logic              frame_done
);
    logic        clr, start_req, launch, dual_ok, next_grp, cur_grp;
    logic        key   [NUM_GRP];
    logic [FNUM_W-1:0] fcnt [NUM_GRP];
    frame_stat_t stat_q;

    assign clr       = ctl_wr && ctl_soft_rst;
    assign start_req = ctl_wr && ctl_start && !clr;
    assign dual_ok   = dual_en && frame_mode;
    assign cur_grp   = dual_ok ? next_grp : 1'b0;

    gfs_ctrl u_ctrl (
        .clk(clk), .rst(rst), .clr(clr), .start_req(start_req),
        .enc_done(enc_done), .busy(busy), .frame_done(frame_done),
        .launch(launch)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_stream
        gfs_stream_track #(.GOP_W(GOP_W), .FNUM_W(FNUM_W)) u_trk (
            .clk(clk), .rst(rst), .clr(clr),
            .adv(launch && (cur_grp == 1'(g))),
            .gop_len(gop_len), .is_key(key[g]), .fnum(fcnt[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            stat_q   <= '0;
            next_grp <= 1'b0;
        end else if (launch) begin
            stat_q.intra <= key[cur_grp];
            stat_q.num   <= fcnt[cur_grp];
            stat_q.grp   <= cur_grp;
            next_grp     <= other_grp(cur_grp, dual_ok);
        end
    end

    assign frame_intra = stat_q.intra;
    assign frame_num   = stat_q.num;
    assign grp_sel     = stat_q.grp;

    // R10
    soft_rst_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!busy && !frame_done && frame_num == '0 && !grp_sel && !frame_intra));
    // R7
    single_grp_chk: assert property (@(posedge clk) disable iff (rst)
        (start_req && !busy && !frame_mode) |=> !grp_sel);
    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && ctl_wr && ctl_start && !ctl_soft_rst) |=> $stable(frame_num));
endmodule

// File: tb/sim_gop_frame_seq.sv
module sim_gop_frame_seq;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl_wr = 0, ctl_start = 0, ctl_soft_rst = 0;
    logic frame_mode = 0, dual_en = 0, enc_done = 0;
    logic [7:0] gop_len = 8'd0;
    logic busy, frame_intra, grp_sel, frame_done;
    logic [8:0] frame_num;

    int n_cmp = 0, n_bad = 0;
    bit started = 0;

    // reference model state
    int m_busy, m_intra, m_num, m_grp, m_done, m_next;
    int m_pos [2];
    int m_cnt [2];

    always #2 clk = ~clk;

    gop_frame_seq u0 (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_start(ctl_start),
        .ctl_soft_rst(ctl_soft_rst), .frame_mode(frame_mode), .dual_en(dual_en),
        .gop_len(gop_len), .enc_done(enc_done), .busy(busy),
        .frame_intra(frame_intra), .frame_num(frame_num), .grp_sel(grp_sel),
        .frame_done(frame_done)
    );

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        started = 1;
        if (rst || (ctl_wr && ctl_soft_rst)) begin
            m_busy = 0; m_intra = 0; m_num = 0; m_grp = 0; m_done = 0; m_next = 0;
            for (int i = 0; i < 2; i++) begin m_pos[i] = 0; m_cnt[i] = 0; end
        end else begin
            m_done = 0;
            if (m_busy == 1) begin
                if (enc_done) begin m_busy = 0; m_done = 1; end
            end else if (ctl_wr && ctl_start) begin
                automatic int d = (dual_en && frame_mode) ? 1 : 0;
                automatic int g = d ? m_next : 0;
                m_intra = (m_pos[g] == 0) ? 1 : 0;
                m_num = m_cnt[g];
                m_grp = g;
                m_cnt[g] = (m_cnt[g] + 1) % 512;
                if (gop_len == 0) m_pos[g] = (m_pos[g] == 0) ? 1 : m_pos[g];
                else m_pos[g] = (m_pos[g] + 1 >= gop_len) ? 0 : m_pos[g] + 1;
                m_next = d ? 1 - g : 0;
                m_busy = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (started) begin
            chk("model busy", busy, m_busy);
            chk("model intra", frame_intra, m_intra);
            chk("model num", frame_num, m_num);
            chk("model grp", grp_sel, m_grp);
            chk("model done", frame_done, m_done);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ctl(bit s, bit r);
        @(negedge clk);
        ctl_wr = 1; ctl_start = s; ctl_soft_rst = r;
        @(negedge clk);
        ctl_wr = 0; ctl_start = 0; ctl_soft_rst = 0;
    endtask

    // one frame: start, capture status, finish
    task automatic frame(output int fi, output int fn, output int fg);
        ctl(1, 0);
        fi = frame_intra; fn = frame_num; fg = grp_sel;
        enc_done = 1;
        @(negedge clk);
        enc_done = 0;
    endtask

    initial begin
        #800000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int fi, fn, fg;
        idle(3);
        rst = 0;
        // R1 reset state
        chk("R1 busy", busy, 0); chk("R1 num", frame_num, 0);
        chk("R1 intra", frame_intra, 0); chk("R1 done", frame_done, 0);
        // R2 zero start write ignored
        ctl(0, 0);
        chk("R2 busy after zero write", busy, 0);
        chk("R2 num after zero write", frame_num, 0);
        // R3 gop 3
        gop_len = 3;
        for (int k = 0; k < 7; k++) begin
            frame(fi, fn, fg);
            chk("R3 intra cadence", fi, (k % 3 == 0) ? 1 : 0);
            chk("R5 frame number", fn, k);
        end
        // R8 start while busy
        ctl(1, 0);
        chk("R8 busy", busy, 1);
        ctl(1, 0);
        chk("R8 num held while busy", frame_num, 7);
        // R9 done timing
        @(negedge clk); enc_done = 1;
        @(negedge clk); enc_done = 0;
        chk("R9 done pulse", frame_done, 1);
        chk("R8 busy cleared", busy, 0);
        @(negedge clk);
        chk("R9 done single cycle", frame_done, 0);
        enc_done = 1; @(negedge clk); enc_done = 0;
        chk("R9 idle done ignored", frame_done, 0);
        // R10 soft reset with start in same write
        frame(fi, fn, fg);
        ctl(1, 1);
        chk("R10 busy", busy, 0); chk("R10 num", frame_num, 0);
        frame(fi, fn, fg);
        chk("R10 counters cleared intra", fi, 1);
        chk("R10 counters cleared num", fn, 0);
        // R4 unbounded gop
        ctl(0, 1);
        gop_len = 0;
        for (int k = 0; k < 5; k++) begin
            frame(fi, fn, fg);
            chk("R4 unbounded intra", fi, (k == 0) ? 1 : 0);
        end
        // R7 dual without frame mode
        ctl(0, 1);
        dual_en = 1; frame_mode = 0; gop_len = 2;
        for (int k = 0; k < 4; k++) begin
            frame(fi, fn, fg);
            chk("R7 group", fg, 0);
            chk("R7 shared count", fn, k);
        end
        // R6 dual mode
        ctl(0, 1);
        frame_mode = 1; gop_len = 2;
        for (int k = 0; k < 8; k++) begin
            frame(fi, fn, fg);
            chk("R6 group alternation", fg, k % 2);
            chk("R6 per-group number", fn, k / 2);
            chk("R6 per-group cadence", fi, ((k / 2) % 2 == 0) ? 1 : 0);
        end
        // R5 wrap at 512
        ctl(0, 1);
        dual_en = 0; frame_mode = 0; gop_len = 0;
        for (int k = 0; k < 513; k++) begin
            frame(fi, fn, fg);
            if (k == 511) chk("R5 last before wrap", fn, 511);
        end
        chk("R5 wrap to zero", fn, 0);
        idle(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule